// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit with Saturating Write-Back

This block keeps a signed accumulator twice the operand width. The accumulator is held as two operand-wide registers: a high half and a low half. On an accumulate strobe it adds a signed product to the accumulator. The product comes from one of two operations:

- **Long:** the full signed operands multiplied together.
- **Word:** only the sign-extended low half-word of each operand, multiplied together.

A saturation-enable input changes how the sum is written back, and the two operations handle it differently:

- The long operation only forces or masks the upper bits of the high half.
- The word operation clamps the low half to the signed operand-width limits and writes 1 into the high half to mark the overflow.

Software-visible control is limited to three strobes:

- a clear strobe;
- separate direct loads for each half;
- the accumulate strobe.

All three act on the next clock edge. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `mac_sat_unit`

## Requirements
- R1: While reset is asserted, and after it is released, both accumulator halves read zero until some strobe changes them.
- R2: Long operation (op_word=0) with sat_en=0: {acc_hi,acc_lo} becomes the old signed {acc_hi,acc_lo} plus signed(op_a)*signed(op_b), wrapped to the accumulator width.
- R3: Word operation (op_word=1) with sat_en=0: the added product is signed(op_a[HW-1:0])*signed(op_b[HW-1:0]); operand bits at and above HW have no effect; the full sum is written back.
- R4: Long operation with sat_en=1 and a negative sum: acc_lo takes the low half of the sum, and acc_hi takes the sum's high half with bits OPW-1 down to OPW/2 forced to one.
- R5: Long operation with sat_en=1 and a non-negative sum: acc_lo takes the low half of the sum, and acc_hi keeps only bits OPW/2-2 down to 0 of the sum's high half, with all other bits zero.
- R6: Word operation with sat_en=1 and a sum below -2^(OPW-1): acc_hi=1 and acc_lo holds a one in the sign bit with all other bits zero.
- R7: Word operation with sat_en=1 and a sum above 2^(OPW-1)-1: acc_hi=1 and acc_lo holds a zero in the sign bit with all other bits one.
- R8: Word operation with sat_en=1 and a sum within the signed OPW-bit range: the ordinary split of the sum is written.
- R9: The clear strobe zeroes both halves on the next edge. It outranks the loads and the accumulate in the same cycle.
- R10: ld_hi writes ld_hi_data into acc_hi, and ld_lo writes ld_lo_data into acc_lo. When either load is active, a same-cycle accumulate is dropped, and a half that is not loaded keeps its value.
- R11: With no clear, load or accumulate strobe, both halves hold their value, whatever the operand and mode inputs do.
- R12: An accumulate takes one clock. Its result appears after the edge that samples the strobe, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr | input | 1 | Zero both accumulator halves |
| ld_hi | input | 1 | Direct load of the high half |
| ld_lo | input | 1 | Direct load of the low half |
| ld_hi_data | input | OPW | Value for the high-half load |
| ld_lo_data | input | OPW | Value for the low-half load |
| acc_en | input | 1 | Accumulate strobe |
| op_word | input | 1 | 0 = long operation, 1 = word operation |
| sat_en | input | 1 | Saturating write-back enable |
| op_a | input | OPW | First signed operand |
| op_b | input | OPW | Second signed operand |
| acc_hi | output | OPW | High half of the accumulator |
| acc_lo | output | OPW | Low half of the accumulator |

## Verification
The bench builds the unit with OPW=8 and HW=4, which gives a 16-bit accumulator.

- **Word operation:** every pair of 4-bit half-words is swept, with junk in the upper operand bits. Each pair is run from accumulator start values that sit at the positive limit, at the negative limit and in between, so both clamp directions and the in-range path are reached with small products.
- **Long operation:** all 256 values of one operand are crossed with sixteen values of the other, from start values chosen so that forcing and masking of the high half both produce visible changes.

Clear, load priority, hold and latency are each checked by directed sequences.

// File: rtl/mac_sat_pkg.sv
package mac_sat_pkg;
  typedef enum logic {
    MAC_LONG = 1'b0,
    MAC_WORD = 1'b1
  } mac_op_e;
endpackage

// File: rtl/mac_rst_sync.sv
module mac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/mac_product.sv
module mac_product
  import mac_sat_pkg::*;
#(
  parameter int OPW = 32,
  parameter int HW  = 16
) (
  input  mac_op_e             op,
  input  logic [OPW-1:0]      op_a,
  input  logic [OPW-1:0]      op_b,
  output logic [2*OPW-1:0]    prod
);
  localparam int ACCW = 2 * OPW;

  logic signed [ACCW-1:0] a_ext;
  logic signed [ACCW-1:0] b_ext;

  // The operand extension depends on the operation: full width or half-word.
  always_comb begin
    if (op == MAC_WORD) begin
      a_ext = {{(ACCW-HW){op_a[HW-1]}}, op_a[HW-1:0]};
      b_ext = {{(ACCW-HW){op_b[HW-1]}}, op_b[HW-1:0]};
    end else begin
      a_ext = {{OPW{op_a[OPW-1]}}, op_a};
      b_ext = {{OPW{op_b[OPW-1]}}, op_b};
    end
    prod = a_ext * b_ext;
  end
endmodule

// File: rtl/mac_writeback.sv
module mac_writeback
  import mac_sat_pkg::*;
#(
  parameter int OPW = 32
) (
  input  mac_op_e          op,
  input  logic             sat_en,
  input  logic [2*OPW-1:0] sum,
  output logic [OPW-1:0]   nxt_hi,
  output logic [OPW-1:0]   nxt_lo
);
  localparam int ACCW = 2 * OPW;
  localparam int HALF = OPW / 2;
  localparam logic [OPW-1:0] LO_MAX   = {1'b0, {(OPW-1){1'b1}}};
  localparam logic [OPW-1:0] LO_MIN   = {1'b1, {(OPW-1){1'b0}}};
  localparam logic [OPW-1:0] HI_FORCE = {{(OPW-HALF){1'b1}}, {HALF{1'b0}}};
  localparam logic [OPW-1:0] HI_KEEP  = {{(OPW-HALF+1){1'b0}}, {(HALF-1){1'b1}}};
  localparam logic [OPW-1:0] HI_MARK  = {{(OPW-1){1'b0}}, 1'b1};

  logic neg;
  logic fits;
  logic over_hi;
  logic under_lo;

  always_comb begin
    neg      = sum[ACCW-1];
    // The sum fits the signed OPW-bit range when its top bits, down to and
    // including the low-half sign bit, are all equal.
    fits     = (&sum[ACCW-1:OPW-1]) || ~(|sum[ACCW-1:OPW-1]);
    over_hi  = !neg && !fits;
    under_lo = neg && !fits;
  end

  always_comb begin
    nxt_hi = sum[ACCW-1:OPW];
    nxt_lo = sum[OPW-1:0];
    if (sat_en) begin
      if (op == MAC_LONG) begin
        if (neg) nxt_hi = sum[ACCW-1:OPW] | HI_FORCE;
        else     nxt_hi = sum[ACCW-1:OPW] & HI_KEEP;
      end else begin
        if (under_lo) begin
          nxt_hi = HI_MARK;
          nxt_lo = LO_MIN;
        end else if (over_hi) begin
          nxt_hi = HI_MARK;
          nxt_lo = LO_MAX;
        end
      end
    end
  end
endmodule

// File: rtl/mac_acc_regs.sv
module mac_acc_regs #(
  parameter int OPW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           ld_hi,
  input  logic           ld_lo,
  input  logic [OPW-1:0] ld_hi_data,
  input  logic [OPW-1:0] ld_lo_data,
  input  logic           acc_en,
  input  logic [OPW-1:0] wb_hi,
  input  logic [OPW-1:0] wb_lo,
  output logic [OPW-1:0] acc_hi,
  output logic [OPW-1:0] acc_lo
);
  logic [OPW-1:0] hi_q, lo_q, hi_d, lo_d;
  logic           hi_en, lo_en, acc_go;

  // Priority: clear, then direct loads, then accumulate.
  always_comb begin
    acc_go = acc_en && !clr && !ld_hi && !ld_lo;
    hi_en  = clr || ld_hi || acc_go;
    lo_en  = clr || ld_lo || acc_go;
    if (clr)        hi_d = '0;
    else if (ld_hi) hi_d = ld_hi_data;
    else            hi_d = wb_hi;
    if (clr)        lo_d = '0;
    else if (ld_lo) lo_d = ld_lo_data;
    else            lo_d = wb_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (hi_en) begin
      hi_q <= hi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (lo_en) begin
      lo_q <= lo_d;
    end
  end

  assign acc_hi = hi_q;
  assign acc_lo = lo_q;

  a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_hi == '0) && (acc_lo == '0));

  a_r10_load_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_hi && !clr) |=> acc_hi == $past(ld_hi_data));

  a_r10_load_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_lo && !clr) |=> acc_lo == $past(ld_lo_data));

  a_r10_unloaded_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_hi && !ld_lo && !clr) |=> $stable(acc_lo));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld_hi && !ld_lo && !acc_en) |=> ($stable(acc_hi) && $stable(acc_lo)));
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
  import mac_sat_pkg::*;
#(
  parameter int OPW = 32,
  parameter int HW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           ld_hi,
  input  logic           ld_lo,
  input  logic [OPW-1:0] ld_hi_data,
  input  logic [OPW-1:0] ld_lo_data,
  input  logic           acc_en,
  input  logic           op_word,
  input  logic           sat_en,
  input  logic [OPW-1:0] op_a,
  input  logic [OPW-1:0] op_b,
  output logic [OPW-1:0] acc_hi,
  output logic [OPW-1:0] acc_lo
);
  localparam int ACCW = 2 * OPW;
  localparam int HALF = OPW / 2;
  localparam logic [OPW-1:0] LO_MAX = {1'b0, {(OPW-1){1'b1}}};
  localparam logic [OPW-1:0] LO_MIN = {1'b1, {(OPW-1){1'b0}}};

  logic            rst_s_n;
  mac_op_e         op;
  logic [ACCW-1:0] prod;
  logic [ACCW-1:0] sum;
  logic [OPW-1:0]  wb_hi, wb_lo;
  logic            go_obs;

  assign op = mac_op_e'(op_word);

  mac_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  mac_product #(.OPW(OPW), .HW(HW)) u_prod (
    .op   (op),
    .op_a (op_a),
    .op_b (op_b),
    .prod (prod)
  );

  assign sum = {acc_hi, acc_lo} + prod;

  mac_writeback #(.OPW(OPW)) u_wb (
    .op     (op),
    .sat_en (sat_en),
    .sum    (sum),
    .nxt_hi (wb_hi),
    .nxt_lo (wb_lo)
  );

  mac_acc_regs #(.OPW(OPW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .clr        (clr),
    .ld_hi      (ld_hi),
    .ld_lo      (ld_lo),
    .ld_hi_data (ld_hi_data),
    .ld_lo_data (ld_lo_data),
    .acc_en     (acc_en),
    .wb_hi      (wb_hi),
    .wb_lo      (wb_lo),
    .acc_hi     (acc_hi),
    .acc_lo     (acc_lo)
  );

  assign go_obs = acc_en && !clr && !ld_hi && !ld_lo;

  // Long-form saturation leaves either the upper half of acc_hi all ones or
  // everything above bit HALF-2 of acc_hi clear (R4, R5).
  a_r5_long_sat_shape: assert property (@(posedge clk) disable iff (!rst_s_n)
    (go_obs && sat_en && !op_word) |=>
      ((&acc_hi[OPW-1:HALF]) || (acc_hi[OPW-1:HALF-1] == '0)));

  // Word-form saturation leaves either a clamped pair marked by acc_hi == 1,
  // or an in-range value whose high half is the sign extension of acc_lo (R6, R7, R8).
  a_r8_word_sat_shape: assert property (@(posedge clk) disable iff (!rst_s_n)
    (go_obs && sat_en && op_word) |=>
      ((acc_hi == OPW'(1) && (acc_lo == LO_MAX || acc_lo == LO_MIN)) ||
       (acc_hi == {OPW{acc_lo[OPW-1]}})));
endmodule

// File: tb/mac_sat_unit_tb.sv
module mac_sat_unit_tb;
  localparam int OPW  = 8;
  localparam int HW   = 4;
  localparam int ACCW = 2 * OPW;
  localparam int HALF = OPW / 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           clr = 1'b0, ld_hi = 1'b0, ld_lo = 1'b0;
  logic [OPW-1:0] ld_hi_data = '0, ld_lo_data = '0;
  logic           acc_en = 1'b0, op_word = 1'b0, sat_en = 1'b0;
  logic [OPW-1:0] op_a = '0, op_b = '0;
  logic [OPW-1:0] acc_hi, acc_lo;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  mac_sat_unit #(.OPW(OPW), .HW(HW)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ld_hi(ld_hi), .ld_lo(ld_lo),
    .ld_hi_data(ld_hi_data), .ld_lo_data(ld_lo_data), .acc_en(acc_en),
    .op_word(op_word), .sat_en(sat_en), .op_a(op_a), .op_b(op_b),
    .acc_hi(acc_hi), .acc_lo(acc_lo)
  );

  task automatic chk(input string tag, input logic [OPW-1:0] eh, input logic [OPW-1:0] el);
    n_run++;
    if (acc_hi !== eh || acc_lo !== el) begin
      n_fail++;
      $display("FAIL %s: got %h_%h expected %h_%h", tag, acc_hi, acc_lo, eh, el);
    end
  endtask

  // Arithmetic reference from the requirements.
  task automatic model(input bit word, input bit sat, input logic [OPW-1:0] a,
                       input logic [OPW-1:0] b, input logic [OPW-1:0] h0,
                       input logic [OPW-1:0] l0, output logic [OPW-1:0] eh,
                       output logic [OPW-1:0] el, output string tag);
    longint acc, p, s, sv, lim;
    logic [ACCW-1:0] r;
    acc = longint'($signed({h0, l0}));
    if (word) p = longint'($signed(a[HW-1:0])) * longint'($signed(b[HW-1:0]));
    else      p = longint'($signed(a)) * longint'($signed(b));
    s  = acc + p;
    r  = ACCW'(s);
    sv = longint'($signed(r));
    eh = r[ACCW-1:OPW];
    el = r[OPW-1:0];
    lim = longint'(1) << (OPW - 1);
    tag = word ? "R3" : "R2";
    if (sat) begin
      if (!word) begin
        if (sv < 0) begin
          eh = eh | {{(OPW-HALF){1'b1}}, {HALF{1'b0}}};
          tag = "R4";
        end else begin
          eh = eh & {{(OPW-HALF+1){1'b0}}, {(HALF-1){1'b1}}};
          tag = "R5";
        end
      end else if (sv < -lim) begin
        eh = OPW'(1); el = {1'b1, {(OPW-1){1'b0}}}; tag = "R6";
      end else if (sv > lim - 1) begin
        eh = OPW'(1); el = {1'b0, {(OPW-1){1'b1}}}; tag = "R7";
      end else begin
        tag = "R8";
      end
    end
  endtask

  task automatic run_one(input bit word, input bit sat, input logic [OPW-1:0] a,
                         input logic [OPW-1:0] b, input logic [OPW-1:0] h0,
                         input logic [OPW-1:0] l0);
    logic [OPW-1:0] eh, el;
    string tag;
    @(negedge clk);
    ld_hi = 1'b1; ld_lo = 1'b1; ld_hi_data = h0; ld_lo_data = l0;
    @(negedge clk);
    ld_hi = 1'b0; ld_lo = 1'b0;
    acc_en = 1'b1; op_word = word; sat_en = sat; op_a = a; op_b = b;
    @(negedge clk);
    acc_en = 1'b0;
    model(word, sat, a, b, h0, l0, eh, el, tag);
    chk(tag, eh, el);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL R12: watchdog expired, got no completion expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [OPW-1:0] starts_w [4];
    logic [OPW-1:0] starts_l [3];
    logic [OPW-1:0] eh, el;
    string tag;
    starts_w = '{8'h00, 8'h7F, 8'h80, 8'h40};
    starts_l = '{8'h00, 8'h7F, 8'h81};

    // R1: reset state, with strobes held inactive
    repeat (3) @(negedge clk);
    chk("R1 during reset", '0, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", '0, '0);

    // R12: result appears only after the sampling edge
    @(negedge clk);
    ld_hi = 1'b1; ld_lo = 1'b1; ld_hi_data = 8'h00; ld_lo_data = 8'h05;
    @(negedge clk);
    ld_hi = 1'b0; ld_lo = 1'b0;
    acc_en = 1'b1; op_word = 1'b0; sat_en = 1'b0; op_a = 8'd3; op_b = 8'd4;
    #4;
    chk("R12 before edge", 8'h00, 8'h05);
    @(negedge clk);
    acc_en = 1'b0;
    chk("R12 after edge", 8'h00, 8'h11);

    // R11: idle cycles with moving operands and modes
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      op_a = OPW'(i * 37); op_b = OPW'(i * 11 + 1); op_word = i[0]; sat_en = i[1];
    end
    @(negedge clk);
    chk("R11 hold", 8'h00, 8'h11);

    // R10: single-half load drops the accumulate, other half kept
    @(negedge clk);
    ld_hi = 1'b1; ld_hi_data = 8'hA5; acc_en = 1'b1; op_word = 1'b0;
    sat_en = 1'b0; op_a = 8'd9; op_b = 8'd9;
    @(negedge clk);
    ld_hi = 1'b0; acc_en = 1'b0;
    chk("R10 hi load", 8'hA5, 8'h11);
    ld_lo = 1'b1; ld_lo_data = 8'h3C; acc_en = 1'b1;
    @(negedge clk);
    ld_lo = 1'b0; acc_en = 1'b0;
    chk("R10 lo load", 8'hA5, 8'h3C);

    // R9: clear outranks loads and accumulate
    clr = 1'b1; ld_hi = 1'b1; ld_lo = 1'b1; acc_en = 1'b1;
    ld_hi_data = 8'hFF; ld_lo_data = 8'hFF;
    @(negedge clk);
    clr = 1'b0; ld_hi = 1'b0; ld_lo = 1'b0; acc_en = 1'b0;
    chk("R9 clear", 8'h00, 8'h00);

    // R2: back-to-back long accumulates, one per cycle, from zero
    @(negedge clk);
    acc_en = 1'b1; op_word = 1'b0; sat_en = 1'b0; op_a = 8'hF0; op_b = 8'h10;
    @(negedge clk);
    op_a = 8'h7F; op_b = 8'h7F;
    @(negedge clk);
    acc_en = 1'b0;
    model(1'b0, 1'b0, 8'h7F, 8'h7F, 8'hFF, 8'h00, eh, el, tag);
    chk("R2 back-to-back", eh, el);

    // Word operation sweep: all half-word pairs, junk in upper bits (R3, R6, R7, R8)
    for (int s = 0; s < 2; s++)
      for (int st = 0; st < 4; st++)
        for (int i = 0; i < 16; i++)
          for (int k = 0; k < 16; k++)
            run_one(1'b1, s[0], {4'(i * 3 + k), 4'(i)}, {4'(k * 5 + 1), 4'(k)},
                    {8{starts_w[st][7]}}, starts_w[st]);

    // Long operation sweep (R2, R4, R5)
    for (int s = 0; s < 2; s++)
      for (int st = 0; st < 3; st++)
        for (int a = 0; a < 256; a++)
          for (int k = 0; k < 16; k++)
            run_one(1'b0, s[0], OPW'(a), OPW'(k * 17), starts_l[st], 8'h5A);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule